// File: doc/BRIEF.md
# Block Address Translation Unit

This unit sits in front of paged address translation and maps an effective address to a real address through four programmable block windows. Each window is a pair of registers. The upper word holds the block's effective base, a length field that sets the block size, and separate enable bits for supervisor and problem (user) state. The lower word holds the real base and a two-bit protection code. A translate request carries an address, an access type, the privilege state and a relocation enable. One clock later the unit returns one of three results. A hit delivers a real address. A fault reports a protection violation. A miss tells the requester to fall back on paged translation.

Software programs the windows through a simple write port that selects a pair and selects the upper or lower word. The block size is a power of two of at least 128 KiB, formed from a mask that the length field widens. When relocation is off, the address passes through unchanged.

Top module: `block_xlate`

## Requirements
- R1: After reset, every window's supervisor and problem enable bits are clear. A relocated request therefore returns a miss, and rsp_valid is low until a request arrives.
- R2: With req_reloc low, the response is a hit with rsp_ra equal to req_ea, whatever the access type, privilege or window contents.
- R3: A window takes part in matching only when the enable bit for the current state is set. Upper bit 1 enables supervisor state and upper bit 0 enables problem state. req_user=1 selects problem state.
- R4: The offset mask of a window is its 11-bit length field, upper word bits [12:2], placed at bits [27:17], with bits [16:0] all ones. Bits [31:28] always take part in the compare.
- R5: An address matches a window when (EA AND NOT mask) equals the effective base, which is upper word bits [31:17] with zeros below.
- R6: When several enabled windows match, the lowest-numbered one decides the result.
- R7: On a hit through a window, rsp_ra = (EA AND mask) OR (lower word bits [31:17] with zeros below).
- R8: The protection code is lower word bits [1:0]. Code 00 denies every access. Codes 01 and 11 allow reads and fetches and deny writes. Code 10 allows everything. The access encoding on req_acc is 00 read, 01 write, 10 fetch, and 11 also fetch.
- R9: A denied access gives rsp_fault with rsp_ra = 0.
- R10: When no enabled window matches a relocated request, the response is rsp_miss with rsp_ra = 0.
- R11: rsp_valid follows req_valid by exactly one cycle. While rsp_valid is high, exactly one of hit, fault and miss is set. While it is low, all three flags are clear and rsp_ra is 0.
- R12: A register write (cfg_pair selects the window, cfg_upper=1 selects the upper word) applies to requests issued in later cycles. A request issued in the same cycle as the write sees the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_pair | input | 2 | Window index for the write |
| cfg_upper | input | 1 | 1 writes the upper word, 0 writes the lower word |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Translate request strobe |
| req_ea | input | 32 | Effective address |
| req_acc | input | 2 | Access type: 00 read, 01 write, 10/11 fetch |
| req_user | input | 1 | 1 for problem state, 0 for supervisor state |
| req_reloc | input | 1 | Relocation enable |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_ra | output | 32 | Real address (0 on fault or miss) |
| rsp_hit | output | 1 | Translation produced |
| rsp_fault | output | 1 | Protection violation |
| rsp_miss | output | 1 | No window matched |

## Verification
The hardest case to reach is two enabled windows that overlap, where the lower-numbered one must win even though the higher one would give a different address or a different protection outcome. Random register values almost never produce such an overlap. Directed steps therefore program a large window and a small window over the same base, then disable the winner to expose the other one. A second case needs a register write and a request in the same cycle; a dedicated step issues both at once. The random phase aligns each block base to its own mask and aims most addresses inside a chosen window, so that hits, faults and misses all occur often.

// File: rtl/bx_pkg.sv
package bx_pkg;
  localparam int XW     = 32;
  localparam int OW     = 17;
  localparam int LW     = 11;
  localparam int IW     = XW - OW;
  localparam int LEN_LO = 2;
  localparam int PAD_W  = XW - OW - LW;

  typedef enum logic [1:0] {
    ACC_RD     = 2'b00,
    ACC_WR     = 2'b01,
    ACC_IF     = 2'b10,
    ACC_IF_ALT = 2'b11
  } acc_e;

  typedef struct packed {
    logic [IW-1:0] epi;
    logic [LW-1:0] len;
    logic          sup_on;
    logic          usr_on;
  } upr_t;

  typedef struct packed {
    logic [IW-1:0] rpn;
    logic [1:0]    pp;
  } lwr_t;

  function automatic logic [XW-1:0] blk_mask(input logic [LW-1:0] len);
    return {{PAD_W{1'b0}}, len, {OW{1'b1}}};
  endfunction

  function automatic logic pair_on(input upr_t u, input logic user);
    return user ? u.usr_on : u.sup_on;
  endfunction

  function automatic logic ea_hits(input logic [XW-1:0] ea, input upr_t u);
    return (ea & ~blk_mask(u.len)) == {u.epi, {OW{1'b0}}};
  endfunction

  function automatic logic [XW-1:0] blk_ra(input logic [XW-1:0] ea,
                                           input logic [LW-1:0] len,
                                           input logic [IW-1:0] rpn);
    return (ea & blk_mask(len)) | {rpn, {OW{1'b0}}};
  endfunction

  function automatic logic prot_ok(input logic [1:0] pp, input acc_e acc);
    case (pp)
      2'b00:   return 1'b0;
      2'b10:   return 1'b1;
      default: return acc != ACC_WR;
    endcase
  endfunction
endpackage

// File: rtl/bx_regs.sv
module bx_regs
  import bx_pkg::*;
#(
  parameter int NPAIR = 4,
  localparam int PW = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [PW-1:0] cfg_pair,
  input  logic          cfg_upper,
  input  logic [XW-1:0] cfg_wdata,
  output upr_t          upr_q [NPAIR],
  output lwr_t          lwr_q [NPAIR]
);
  upr_t upr_d;
  lwr_t lwr_d;
  logic unused_wbits;

  assign upr_d = '{epi: cfg_wdata[XW-1:OW],
                   len: cfg_wdata[LEN_LO+LW-1:LEN_LO],
                   sup_on: cfg_wdata[1],
                   usr_on: cfg_wdata[0]};
  assign lwr_d = '{rpn: cfg_wdata[XW-1:OW], pp: cfg_wdata[1:0]};
  assign unused_wbits = ^cfg_wdata[OW-1:LEN_LO+LW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAIR; i++) begin
        upr_q[i] <= '0;
        lwr_q[i] <= '0;
      end
    end else if (cfg_we) begin
      for (int i = 0; i < NPAIR; i++) begin
        if (cfg_pair == PW'(i)) begin
          if (cfg_upper) upr_q[i] <= upr_d;
          else           lwr_q[i] <= lwr_d;
        end
      end
    end
  end
endmodule

// File: rtl/bx_match.sv
module bx_match
  import bx_pkg::*;
#(
  parameter int NPAIR = 4
) (
  input  logic [XW-1:0]    ea,
  input  logic             user,
  input  upr_t             upr [NPAIR],
  output logic [NPAIR-1:0] en_vec,
  output logic [NPAIR-1:0] hit_vec
);
  for (genvar gi = 0; gi < NPAIR; gi++) begin : g_pair
    assign en_vec[gi]  = pair_on(upr[gi], user);
    assign hit_vec[gi] = en_vec[gi] && ea_hits(ea, upr[gi]);
  end
endmodule

// File: rtl/bx_resolve.sv
module bx_resolve
  import bx_pkg::*;
#(
  parameter int NPAIR = 4,
  localparam int PW = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic [NPAIR-1:0] hit_vec,
  input  upr_t             upr [NPAIR],
  input  lwr_t             lwr [NPAIR],
  input  logic [XW-1:0]    ea,
  input  logic [1:0]       acc,
  input  logic             reloc,
  output logic             any_match,
  output logic [1:0]       sel_prot,
  output logic             nxt_hit,
  output logic             nxt_fault,
  output logic             nxt_miss,
  output logic [XW-1:0]    nxt_ra
);
  logic [PW-1:0] sel_idx;
  logic          allow;

  always_comb begin
    sel_idx = '0;
    for (int i = NPAIR - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel_idx = PW'(i);
    end
  end

  assign any_match = |hit_vec;
  assign sel_prot  = lwr[sel_idx].pp;
  assign allow     = prot_ok(sel_prot, acc_e'(acc));

  always_comb begin
    nxt_hit   = 1'b0;
    nxt_fault = 1'b0;
    nxt_miss  = 1'b0;
    nxt_ra    = '0;
    if (!reloc) begin
      nxt_hit = 1'b1;
      nxt_ra  = ea;
    end else if (!any_match) begin
      nxt_miss = 1'b1;
    end else if (!allow) begin
      nxt_fault = 1'b1;
    end else begin
      nxt_hit = 1'b1;
      nxt_ra  = blk_ra(ea, upr[sel_idx].len, lwr[sel_idx].rpn);
    end
  end
endmodule

// File: rtl/block_xlate.sv
module block_xlate
  import bx_pkg::*;
#(
  parameter int NPAIR = 4,
  localparam int PW = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [PW-1:0] cfg_pair,
  input  logic          cfg_upper,
  input  logic [XW-1:0] cfg_wdata,
  input  logic          req_valid,
  input  logic [XW-1:0] req_ea,
  input  logic [1:0]    req_acc,
  input  logic          req_user,
  input  logic          req_reloc,
  output logic          rsp_valid,
  output logic [XW-1:0] rsp_ra,
  output logic          rsp_hit,
  output logic          rsp_fault,
  output logic          rsp_miss
);
  upr_t             upr_q [NPAIR];
  lwr_t             lwr_q [NPAIR];
  logic [NPAIR-1:0] pair_en;
  logic [NPAIR-1:0] pair_hit;
  logic             any_match;
  logic [1:0]       sel_prot;
  logic             nxt_hit, nxt_fault, nxt_miss;
  logic [XW-1:0]    nxt_ra;
  logic             unused_en;

  assign unused_en = ^pair_en;

  bx_regs #(.NPAIR(NPAIR)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pair(cfg_pair),
    .cfg_upper(cfg_upper), .cfg_wdata(cfg_wdata),
    .upr_q(upr_q), .lwr_q(lwr_q)
  );

  bx_match #(.NPAIR(NPAIR)) u_match (
    .ea(req_ea), .user(req_user), .upr(upr_q),
    .en_vec(pair_en), .hit_vec(pair_hit)
  );

  bx_resolve #(.NPAIR(NPAIR)) u_resolve (
    .hit_vec(pair_hit), .upr(upr_q), .lwr(lwr_q), .ea(req_ea),
    .acc(req_acc), .reloc(req_reloc), .any_match(any_match),
    .sel_prot(sel_prot), .nxt_hit(nxt_hit), .nxt_fault(nxt_fault),
    .nxt_miss(nxt_miss), .nxt_ra(nxt_ra)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_ra    <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && nxt_hit;
      rsp_fault <= req_valid && nxt_fault;
      rsp_miss  <= req_valid && nxt_miss;
      rsp_ra    <= req_valid ? nxt_ra : '0;
    end
  end
endmodule

// File: rtl/bx_chk.sv
module bx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_reloc,
  input logic [1:0]  req_acc,
  input logic [31:0] req_ea,
  input logic        any_match,
  input logic [1:0]  sel_prot,
  input logic        rsp_valid,
  input logic [31:0] rsp_ra,
  input logic        rsp_hit,
  input logic        rsp_fault,
  input logic        rsp_miss
);
  assert_one_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_fault, rsp_miss}) == 1);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ({rsp_hit, rsp_fault, rsp_miss} == 3'b000 && rsp_ra == 32'h0));

  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_reloc) |=> (rsp_hit && rsp_ra == $past(req_ea)));

  assert_deny_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_reloc && any_match && sel_prot == 2'b00) |=> rsp_fault);

  assert_write_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_reloc && any_match && req_acc == 2'b01 && sel_prot != 2'b10)
      |=> rsp_fault);

  assert_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_reloc && !any_match) |=> (rsp_miss && rsp_ra == 32'h0));

  assert_fault_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_ra == 32'h0);
endmodule

bind block_xlate bx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_reloc(req_reloc),
  .req_acc(req_acc), .req_ea(req_ea), .any_match(any_match),
  .sel_prot(sel_prot), .rsp_valid(rsp_valid), .rsp_ra(rsp_ra),
  .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_miss(rsp_miss)
);

// File: tb/block_xlate_test.sv
`timescale 1ns/1ps
module block_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_pair = '0;
  logic        cfg_upper = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_ea = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic        req_reloc = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_ra;
  logic        rsp_hit, rsp_fault, rsp_miss;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [31:0] um [4];
  logic [31:0] lm [4];

  always #2.5 clk = ~clk;

  block_xlate uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pair(cfg_pair),
    .cfg_upper(cfg_upper), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_ea(req_ea), .req_acc(req_acc), .req_user(req_user),
    .req_reloc(req_reloc), .rsp_valid(rsp_valid), .rsp_ra(rsp_ra),
    .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_miss(rsp_miss)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R11 watchdog: actual cycles=%0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] win_mask(input logic [31:0] u);
    return (((u >> 2) & 32'h7FF) << 17) | 32'h0001_FFFF;
  endfunction

  // Expected {hit, fault, miss, ra} from the requirements.
  function automatic logic [34:0] ref_xl(input logic [31:0] ea, input logic [1:0] acc,
                                         input logic user, input logic reloc);
    if (!reloc) return {3'b100, ea};
    for (int k = 0; k < 4; k++) begin
      logic [31:0] m;
      logic        en;
      logic [1:0]  pp;
      en = user ? um[k][0] : um[k][1];
      m  = win_mask(um[k]);
      if (en && ((ea & ~m) == (um[k] & 32'hFFFE_0000))) begin
        pp = lm[k][1:0];
        if (pp == 2'b10 || (pp != 2'b00 && acc != 2'b01))
          return {3'b100, (ea & m) | (lm[k] & 32'hFFFE_0000)};
        return {3'b010, 32'h0};
      end
    end
    return {3'b001, 32'h0};
  endfunction

  task automatic chk(input string tag, input logic [35:0] got, input logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual v/h/f/m=%b ra=%h expected v/h/f/m=%b ra=%h",
               tag, got[35:32], got[31:0], exp[35:32], exp[31:0]);
    end
  endtask

  task automatic wr(input logic [1:0] p, input logic up, input logic [31:0] d);
    cfg_we = 1'b1; cfg_pair = p; cfg_upper = up; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (up) um[p] = d; else lm[p] = d;
  endtask

  task automatic xreq(input string tag, input logic [31:0] ea, input logic [1:0] acc,
                      input logic user, input logic reloc);
    logic [34:0] e;
    e = ref_xl(ea, acc, user, reloc);
    req_valid = 1'b1; req_ea = ea; req_acc = acc; req_user = user; req_reloc = reloc;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, {rsp_valid, rsp_hit, rsp_fault, rsp_miss, rsp_ra}, {1'b1, e});
  endtask

  // Write and request in the same cycle (R12).
  task automatic wr_and_req(input logic [1:0] p, input logic up, input logic [31:0] d,
                            input logic [31:0] ea, input logic [1:0] acc, input logic user);
    logic [34:0] e;
    e = ref_xl(ea, acc, user, 1'b1);
    cfg_we = 1'b1; cfg_pair = p; cfg_upper = up; cfg_wdata = d;
    req_valid = 1'b1; req_ea = ea; req_acc = acc; req_user = user; req_reloc = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    if (up) um[p] = d; else lm[p] = d;
    chk("R12 same-cycle write uses old value", {rsp_valid, rsp_hit, rsp_fault, rsp_miss, rsp_ra}, {1'b1, e});
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin um[k] = '0; lm[k] = '0; end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset idle", {rsp_valid, rsp_hit, rsp_fault, rsp_miss, rsp_ra}, 36'h0);
    xreq("R1 miss after reset", 32'h1234_5678, 2'b00, 1'b0, 1'b1);
    xreq("R1 miss after reset user", 32'h0000_0000, 2'b10, 1'b1, 1'b1);
    @(negedge clk);
    chk("R11 idle after request", {rsp_valid, rsp_hit, rsp_fault, rsp_miss, rsp_ra}, 36'h0);

    // Window 0: 128 KiB at 0x1000_0000, supervisor only, real 0x8000_0000, all access.
    wr(2'd0, 1'b1, 32'h1000_0002);
    wr(2'd0, 1'b0, 32'h8000_0002);
    xreq("R5 R7 basic hit", 32'h1001_2345, 2'b00, 1'b0, 1'b1);
    xreq("R3 supervisor-only window misses in problem state", 32'h1001_2345, 2'b00, 1'b1, 1'b1);
    xreq("R4 minimum block edge", 32'h1002_0000, 2'b00, 1'b0, 1'b1);
    xreq("R2 passthrough write", 32'h1001_2345, 2'b01, 1'b0, 1'b0);
    xreq("R2 passthrough user fetch", 32'hDEAD_BEEF, 2'b10, 1'b1, 1'b0);

    // Window 1: 2 MiB at 0x2000_0000, problem only, real 0x4000_0000, read/fetch only.
    wr(2'd1, 1'b1, 32'h2000_003D);
    wr(2'd1, 1'b0, 32'h4000_0001);
    xreq("R8 R9 write denied on code 01", 32'h201F_FFFF, 2'b01, 1'b1, 1'b1);
    xreq("R4 R7 fetch in 2 MiB block", 32'h201F_FFFF, 2'b10, 1'b1, 1'b1);
    xreq("R8 fetch alt code", 32'h2010_0000, 2'b11, 1'b1, 1'b1);
    xreq("R4 R10 just past block", 32'h2020_0000, 2'b00, 1'b1, 1'b1);
    xreq("R3 problem-only window misses in supervisor", 32'h2000_0010, 2'b00, 1'b0, 1'b1);

    // Windows 2 and 3 overlap at 0x3000_0000.
    wr(2'd2, 1'b1, 32'h3000_1FFE);
    wr(2'd2, 1'b0, 32'h5000_0002);
    wr(2'd3, 1'b1, 32'h3000_0002);
    wr(2'd3, 1'b0, 32'h6000_0000);
    xreq("R6 lowest window wins", 32'h3000_0100, 2'b01, 1'b0, 1'b1);
    xreq("R4 256 MiB block top", 32'h3FFF_FFFC, 2'b00, 1'b0, 1'b1);
    wr(2'd2, 1'b1, 32'h3000_1FFC);
    xreq("R8 R12 code 00 denies read after disable", 32'h3000_0100, 2'b00, 1'b0, 1'b1);
    xreq("R8 code 00 denies fetch", 32'h3000_0100, 2'b10, 1'b0, 1'b1);
    wr(2'd3, 1'b0, 32'h6000_0003);
    xreq("R8 code 11 allows read", 32'h3000_0100, 2'b00, 1'b0, 1'b1);
    xreq("R8 code 11 denies write", 32'h3000_0100, 2'b01, 1'b0, 1'b1);
    xreq("R5 misaligned base never matches", 32'h3002_0000, 2'b00, 1'b0, 1'b1);

    // Same-cycle write, then the following request sees the new value.
    wr_and_req(2'd0, 1'b0, 32'h9000_0002, 32'h1000_0040, 2'b00, 1'b0);
    xreq("R12 new value in next request", 32'h1000_0040, 2'b00, 1'b0, 1'b1);

    // Random phase.
    for (int n = 0; n < 600; n++) begin
      int sel;
      sel = $urandom % 10;
      if (sel < 3) begin
        logic [31:0] u, m;
        logic [1:0]  p;
        p = 2'($urandom % 4);
        u = $urandom;
        if ($urandom % 2) u[12:2] = 11'($urandom % 16);
        m = win_mask(u);
        u = u & ~(m & 32'hFFFE_0000);
        if ($urandom % 2) wr(p, 1'b1, u);
        else              wr(p, 1'b0, $urandom);
      end else begin
        logic [31:0] ea, m;
        int k;
        k = $urandom % 4;
        m = win_mask(um[k]);
        ea = ($urandom % 8 == 0) ? $urandom : ((um[k] & ~m) | ($urandom & m));
        xreq("R3 R5 R6 R7 R8 R10 random", ea, 2'($urandom), 1'($urandom),
             ($urandom % 8) != 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule